// File: doc/BRIEF.md
# GPIO Direction and Masked-Write Output Bank

This block is a bank of 32 general-purpose I/O pins behind a plain 32-bit register bus. Direction is held per pin and changes only through two strobe registers. One register turns the pins named by its one-bits into outputs. The other turns them back into inputs. Zero bits in either register leave their pins alone, so software never has to read the direction, modify it and write it back.

Output levels are written through two half-word registers, one for the lower 16 pins and one for the upper 16. The upper half of each write word is a per-bit enable for the value carried in the lower half. A single pin can therefore be changed with one write, and the other pins in that half keep their levels.

Pin levels arrive asynchronously and pass through a two-flop synchronizer before software can read them. The pad side sees an output-enable vector (the direction) and an output-value vector. The read port is combinational from the address, so a read needs no strobe.

Top module: `gpio_bank`

## Requirements
- R1: A write to offset 0x00 sets the direction bit of every pin whose data bit is 1, making it an output (`pad_oe` bit high). Pins with a 0 data bit keep their direction.
- R2: A write to offset 0x04 clears the direction bit of every pin whose data bit is 1, making it an input (`pad_oe` bit low). Pins with a 0 data bit keep their direction.
- R3: A read of offset 0x00 or 0x04 returns the current direction vector, with bit i equal to 1 when pin i is an output.
- R4: A write to offset 0x08 updates the output value of pin i (0 ≤ i ≤ 15) to data bit i only when data bit i+16 is 1. Other pins keep their values.
- R5: A write to offset 0x0C updates the output value of pin 16+i (0 ≤ i ≤ 15) to data bit i only when data bit i+16 is 1. Other pins keep their values.
- R6: Output values are written and held whatever the direction of the pin. `pad_out` always shows the stored value, and changing direction never alters it.
- R7: A read of offset 0x10 returns the pin levels through two flops. A change on `pin_in` that is set up before clock edge k shows on the read port after edge k+1, and not after edge k.
- R8: While `rst_n` is low at a clock edge, every pin becomes an input, every output value becomes 0 and the synchronizer clears to 0.
- R9: Writes to any offset other than 0x00, 0x04, 0x08 and 0x0C change nothing; this includes writes to 0x10. Reads of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0.
- R10: A read of offset 0x08 returns the output values of pins 15..0 in bits 15:0. A read of offset 0x0C returns the output values of pins 31..16 in bits 15:0. In both cases bits 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pad_oe | output | 32 | Per-pin output enable (1 = output) |
| pad_out | output | 32 | Per-pin output value |

## Verification
The assertions take the write strobe, address and write data to be known and steady around each rising edge. A write is one cycle of `bus_wr` carrying a single address. The bench changes every bus input and `pin_in` only on the falling edge, so each value is settled a half period before it is sampled. The synchronizer property compares the read value with the pin level two edges earlier, and it starts only once two edges have passed since reset. The stimulus holds every pin change for at least one full cycle, so that two-edge history is always defined.

// File: rtl/gpio_bank_pkg.sv
// Package: register offsets and widths shared by the GPIO bank modules.
// Assumes a 32-bit data bus with byte offsets and word-aligned registers.
package gpio_bank_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned HALF_W = BUS_W / 2;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t OFF_DIR_SET = 8'h00;
    localparam addr_t OFF_DIR_CLR = 8'h04;
    localparam addr_t OFF_OUT_LO  = 8'h08;
    localparam addr_t OFF_OUT_HI  = 8'h0C;
    localparam addr_t OFF_PIN_LVL = 8'h10;
endpackage

// File: rtl/gpio_dir_reg.sv
// Module: per-pin direction register driven by set and clear strobes.
// Assumes the set and clear strobes never assert together. If they do, clear wins.
module gpio_dir_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] dir_q
);
    // Direction state: one-bits in the data select pins; zero-bits leave pins untouched.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (clr_stb)
            dir_q <= dir_q & ~bits;
        else if (set_stb)
            dir_q <= dir_q | bits;
    end

    // R1
    // set_only_marks_chk
    set_only_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb && !clr_stb |=> ((dir_q & $past(bits)) == $past(bits))
                             && ((dir_q & ~$past(bits)) == ($past(dir_q) & ~$past(bits))));

    // R2
    // clr_only_marks_chk
    clr_only_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((dir_q & $past(bits)) == '0)
                 && ((dir_q & ~$past(bits)) == ($past(dir_q) & ~$past(bits))));

    // R9
    // dir_hold_chk
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_stb && !clr_stb |=> $stable(dir_q));
endmodule

// File: rtl/gpio_out_half.sv
// Module: one half-bank of output values, written with a per-bit enable mask.
// Assumes the mask and value arrive together on a single write strobe.
module gpio_out_half #(
    parameter int unsigned HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [HW-1:0] mask,
    input  logic [HW-1:0] val,
    output logic [HW-1:0] out_q
);
    // Output value state: only masked bits take the new value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (wr_stb)
            out_q <= (out_q & ~mask) | (val & mask);
    end

    // R4 R5
    // masked_update_chk
    masked_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ((out_q & $past(mask)) == ($past(val) & $past(mask)))
                && ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));

    // R6
    // out_hold_chk
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(out_q));
endmodule

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for asynchronous pin levels.
// Assumes each pin is sampled per bit. Coherence across bits is not guaranteed.
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] data_o
);
    logic [W-1:0] meta_q;
    logic [1:0]   warm_q;

    // Synchronizer chain: first flop catches, second flop settles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            data_o <= '0;
        end else begin
            meta_q <= pin_i;
            data_o <= meta_q;
        end
    end

    // Edge counter since reset, used only to open the latency check window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (warm_q != 2'd2)
            warm_q <= warm_q + 2'd1;
    end

    // R7
    // sync_latency_chk
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (data_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_bank.sv
// Module: 32-pin GPIO register bank, the top level.
// It decodes the bus, holds direction and output values, and returns synchronized levels.
// Assumes one write per strobe cycle. Reads are combinational from the address.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out
);
    localparam int unsigned HALVES = NPINS / HALF_W;

    logic              wr_set, wr_clr;
    logic [HALVES-1:0] wr_half;
    logic [NPINS-1:0]  lvl_sync;
    logic              addr_mapped;

    assign wr_set = bus_wr && (bus_addr == OFF_DIR_SET);
    assign wr_clr = bus_wr && (bus_addr == OFF_DIR_CLR);

    gpio_dir_reg #(.W(NPINS)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_set),
        .clr_stb (wr_clr),
        .bits    (bus_wdata[NPINS-1:0]),
        .dir_q   (pad_oe)
    );

    // One masked output half per 16 pins, each at its own word offset.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam addr_t HALF_OFF = addr_t'(OFF_OUT_LO + 4 * h);
        assign wr_half[h] = bus_wr && (bus_addr == HALF_OFF);
        gpio_out_half #(.HW(HALF_W)) u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (wr_half[h]),
            .mask   (bus_wdata[BUS_W-1:HALF_W]),
            .val    (bus_wdata[HALF_W-1:0]),
            .out_q  (pad_out[h*HALF_W +: HALF_W])
        );
    end

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .data_o (lvl_sync)
    );

    // Read mux: direction, output halves, pin levels; zero elsewhere.
    always_comb begin
        bus_rdata   = '0;
        addr_mapped = 1'b1;
        unique case (bus_addr)
            OFF_DIR_SET, OFF_DIR_CLR: bus_rdata = pad_oe;
            OFF_OUT_LO:  bus_rdata = {{HALF_W{1'b0}}, pad_out[HALF_W-1:0]};
            OFF_OUT_HI:  bus_rdata = {{HALF_W{1'b0}}, pad_out[NPINS-1:HALF_W]};
            OFF_PIN_LVL: bus_rdata = lvl_sync;
            default:     addr_mapped = 1'b0;
        endcase
    end

    // R9
    // unmapped_read_zero_chk
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped |-> (bus_rdata == '0));

    // R9
    // unmapped_write_quiet_chk
    unmapped_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (!addr_mapped || bus_addr == OFF_PIN_LVL))
            |=> ($stable(pad_oe) && $stable(pad_out)));

    // R3
    // dir_readback_chk
    dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_DIR_SET || bus_addr == OFF_DIR_CLR) |-> (bus_rdata == pad_oe));

    // R6
    // dir_change_keeps_out_chk
    dir_change_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=> $stable(pad_out));
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_oe, pad_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // {addr, wdata, expected pad_oe, expected pad_out}
    localparam int NV = 11;
    localparam logic [103:0] VEC [NV] = '{
        {8'h00, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000}, // R1
        {8'h00, 32'hF000_0000, 32'hF000_00FF, 32'h0000_0000}, // R1 zero bits keep
        {8'h04, 32'h0000_000F, 32'hF000_00F0, 32'h0000_0000}, // R2
        {8'h08, 32'hFFFF_A5A5, 32'hF000_00F0, 32'h0000_A5A5}, // R4 full mask
        {8'h08, 32'h00F0_FFFF, 32'hF000_00F0, 32'h0000_A5F5}, // R4 partial mask
        {8'h0C, 32'hFF00_1234, 32'hF000_00F0, 32'h1200_A5F5}, // R5
        {8'h0C, 32'h0000_FFFF, 32'hF000_00F0, 32'h1200_A5F5}, // R5 empty mask
        {8'h20, 32'hFFFF_FFFF, 32'hF000_00F0, 32'h1200_A5F5}, // R9 unmapped
        {8'h10, 32'hFFFF_FFFF, 32'hF000_00F0, 32'h1200_A5F5}, // R9 level reg
        {8'h04, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1200_A5F5}, // R2 R6
        {8'h08, 32'h0001_0000, 32'h0000_0000, 32'h1200_A5F4}  // R6 write as input
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 oe", pad_oe, 32'h0);
        check("R8 out", pad_out, 32'h0);
        bus_read(8'h10, rd); check("R8 sync", rd, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][103:96], VEC[i][95:64]);
            check($sformatf("vec%0d oe", i), pad_oe, VEC[i][63:32]);
            check($sformatf("vec%0d out", i), pad_out, VEC[i][31:0]);
        end

        // R10 output readback
        bus_read(8'h08, rd); check("R10 lo", rd, 32'h0000_A5F4);
        bus_read(8'h0C, rd); check("R10 hi", rd, 32'h0000_1200);
        // R3 direction readback at both offsets
        bus_write(8'h00, 32'h8000_0001);
        bus_read(8'h00, rd); check("R3 set off", rd, 32'h8000_0001);
        bus_read(8'h04, rd); check("R3 clr off", rd, 32'h8000_0001);
        // R9 unmapped reads
        bus_read(8'h14, rd); check("R9 rd 14", rd, 32'h0);
        bus_read(8'h01, rd); check("R9 rd 01", rd, 32'h0);

        // R7 two-edge latency
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        bus_addr = 8'h10;
        @(negedge clk);
        bus_read(8'h10, rd); check("R7 after one edge", rd, 32'h0);
        @(negedge clk);
        bus_read(8'h10, rd); check("R7 after two edges", rd, 32'hDEAD_BEEF);
        pin_in = 32'h0F0F_0F0F;
        repeat (2) @(negedge clk);
        bus_read(8'h10, rd); check("R7 second pattern", rd, 32'h0F0F_0F0F);

        // R8 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 oe mid", pad_oe, 32'h0);
        check("R8 out mid", pad_out, 32'h0);
        bus_read(8'h10, rd); check("R8 sync mid", rd, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule